// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This unit sits beside the datapath of a five-stage in-order pipeline and resolves read-after-write data hazards. Each cycle it compares the source register numbers of the instruction in execute with the destination register numbers held in the memory and write-back stages. It then drives a select for each ALU operand input, the store-data operand included. The selected operand is the freshest in-flight result; when no in-flight result matches, it is the register file value.

A result that is still being loaded cannot reach the ALU in time for the instruction that follows the load. For that case the unit compares the decode-stage source registers against a load sitting in execute. On a match it raises a stall, which freezes the PC and the fetch/decode register, together with a bubble that turns the decode/execute register into a nop. A two-state controller (`ST_FLOW`, `ST_HELD`) keeps that interlock to a single cycle. On a stall, `ST_FLOW` moves to `ST_HELD`. `ST_HELD` suppresses any further stall and always returns to `ST_FLOW` on the next cycle. Once the load has moved to write-back, the ordinary bypass path delivers its data.

Top module: `hazard_unit`

## Requirements
- R1: When `ex_rs` equals a nonzero `mem_rd` with `mem_we` high, `fwd_a_sel` is 2'b10 (take the memory-stage result) in the same cycle.
- R2: When `ex_rs` matches only a nonzero `wb_rd` with `wb_we` high, `fwd_a_sel` is 2'b01 (take the write-back value).
- R3: When both the memory and the write-back stage target the same source register, the younger memory-stage result wins and the select is 2'b10.
- R4: Operand B (`ex_rt`, also the store data) uses the same encoding and priority on `fwd_b_sel`, independently of operand A.
- R5: Register 0 never causes forwarding or a stall. A stage whose write enable is low never causes forwarding or a stall. In these cases the select stays 2'b00 (register file).
- R6: When `ex_is_load` and `ex_we` are high and a nonzero `ex_rd` equals `id_rs` or `id_rt`, `stall` and `bubble` are both 1 in that same cycle (from `ST_FLOW`).
- R7: When the instruction in execute is not a load, no stall occurs even if its destination matches a decode source. When a load's destination matches neither decode source, no stall occurs either.
- R8: A stall lasts exactly one cycle. The cycle after a stall is in `ST_HELD` with `stall` and `bubble` at 0 even if the hazard inputs persist, and the cycle after that is back in `ST_FLOW`.
- R9: A write-back destination that matches only a decode source produces neither a stall nor a select change, because the register file's write-then-read covers that distance.
- R10: While `rst_n` is low, `stall` and `bubble` are 0 and the controller is held in `ST_FLOW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs | input | 5 | Decode-stage first source register |
| id_rt | input | 5 | Decode-stage second source register |
| ex_rs | input | 5 | Execute-stage first source register (operand A) |
| ex_rt | input | 5 | Execute-stage second source register (operand B / store data) |
| ex_rd | input | 5 | Execute-stage destination register |
| ex_we | input | 1 | Execute-stage register write enable |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | Memory-stage destination register |
| mem_we | input | 1 | Memory-stage register write enable |
| wb_rd | input | 5 | Write-back-stage destination register |
| wb_we | input | 1 | Write-back-stage register write enable |
| fwd_a_sel | output | 2 | Operand A select: 00 register file, 01 write-back, 10 memory stage |
| fwd_b_sel | output | 2 | Operand B select, same encoding |
| stall | output | 1 | Freeze PC and fetch/decode register |
| bubble | output | 1 | Load a nop into decode/execute register |

## Verification
Both operand selects, `stall` and `bubble` are combinational on the stage fields. They are due in the same cycle the fields are applied, so the bench drives on the falling edge and samples one nanosecond later, before the next rising edge. Only the stall suppression of R8 goes through a register. That check applies the hazard, samples `stall` high, and then, after exactly one rising edge, samples it low with the same inputs. After a second rising edge it samples `stall` high again.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_t;

    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_HELD = 1'b1
    } ilk_state_t;

endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import hazard_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    output fwd_sel_t      sel
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic mem_hit;
    logic wb_hit;

    assign mem_hit = mem_we && (mem_rd != ZERO_REG) && (mem_rd == src);
    assign wb_hit  = wb_we  && (wb_rd  != ZERO_REG) && (wb_rd  == src);

    // Younger (memory-stage) result takes priority over write-back.
    always_comb begin
        if (mem_hit)     sel = FWD_MEM;
        else if (wb_hit) sel = FWD_WB;
        else             sel = FWD_RF;
    end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_rs,
    input  logic [AW-1:0] id_rt,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_is_load,
    output logic          hit
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic producer_ok;

    assign producer_ok = ex_is_load && ex_we && (ex_rd != ZERO_REG);
    assign hit = producer_ok && ((ex_rd == id_rs) || (ex_rd == id_rt));
endmodule

// File: rtl/interlock_fsm.sv
module interlock_fsm
    import hazard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic stall,
    output logic bubble
);
    ilk_state_t state_q;
    ilk_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOW: if (hit) state_d = ST_HELD;
            ST_HELD: state_d = ST_FLOW;
            default: state_d = ST_FLOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FLOW;
        else        state_q <= state_d;
    end

    always_comb begin
        stall  = 1'b0;
        bubble = 1'b0;
        unique case (state_q)
            ST_FLOW: begin
                stall  = hit && rst_n;
                bubble = hit && rst_n;
            end
            ST_HELD: begin
                stall  = 1'b0;
                bubble = 1'b0;
            end
            default: begin
                stall  = 1'b0;
                bubble = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hazard_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs,
    input  logic [AW-1:0] id_rt,
    input  logic [AW-1:0] ex_rs,
    input  logic [AW-1:0] ex_rt,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_is_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    output logic [1:0]    fwd_a_sel,
    output logic [1:0]    fwd_b_sel,
    output logic          stall,
    output logic          bubble
);
    localparam int NUM_OPS = 2;

    logic [AW-1:0] ex_src [NUM_OPS];
    fwd_sel_t      op_sel [NUM_OPS];
    logic          lu_hit;

    assign ex_src[0] = ex_rs;
    assign ex_src[1] = ex_rt;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        fwd_operand_sel #(.AW(AW)) u_sel (
            .src    (ex_src[g]),
            .mem_rd (mem_rd),
            .mem_we (mem_we),
            .wb_rd  (wb_rd),
            .wb_we  (wb_we),
            .sel    (op_sel[g])
        );
    end

    assign fwd_a_sel = op_sel[0];
    assign fwd_b_sel = op_sel[1];

    load_use_detect #(.AW(AW)) u_lud (
        .id_rs      (id_rs),
        .id_rt      (id_rt),
        .ex_rd      (ex_rd),
        .ex_we      (ex_we),
        .ex_is_load (ex_is_load),
        .hit        (lu_hit)
    );

    interlock_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (lu_hit),
        .stall  (stall),
        .bubble (bubble)
    );
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] id_rs,
    input logic [AW-1:0] id_rt,
    input logic [AW-1:0] ex_rs,
    input logic [AW-1:0] ex_rt,
    input logic [AW-1:0] ex_rd,
    input logic          ex_we,
    input logic          ex_is_load,
    input logic [AW-1:0] mem_rd,
    input logic          mem_we,
    input logic [AW-1:0] wb_rd,
    input logic          wb_we,
    input logic [1:0]    fwd_a_sel,
    input logic [1:0]    fwd_b_sel,
    input logic          stall,
    input logic          bubble
);
    // R3: memory stage wins whenever it matches operand A
    a_r3_mem_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_rd != '0 && mem_rd == ex_rs) |-> fwd_a_sel == 2'b10);

    // R4: same for operand B
    a_r4_b_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_rd != '0 && mem_rd == ex_rt) |-> fwd_b_sel == 2'b10);

    // R5: register 0 is never bypassed
    a_r5_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs == '0) |-> fwd_a_sel == 2'b00);

    // R6: stall and bubble always travel together
    a_r6_pair: assert property (@(posedge clk) disable iff (!rst_n)
        stall == bubble);

    // R7: only a writing load can cause a stall
    a_r7_load_only: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ex_is_load && ex_we));

    // R8: stall never persists into the next cycle
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // Select code 2'b11 is never produced
    a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11);
endmodule

bind hazard_unit hazard_unit_chk #(.AW(AW)) chk_i (.*);

// File: tb/hazard_unit_tb_top.sv
module hazard_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
    logic       ex_we, ex_is_load, mem_we, wb_we;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic       stall, bubble;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hazard_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .id_rs(id_rs), .id_rt(id_rt), .ex_rs(ex_rs), .ex_rt(ex_rt),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .stall(stall), .bubble(bubble)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Apply stage fields on the falling edge, sample 1 ns later.
    task automatic apply(input logic [4:0] irs, irt, ers, ert, erd,
                         input logic ewe, eld,
                         input logic [4:0] mrd, input logic mwe,
                         input logic [4:0] wrd, input logic wwe);
        @(negedge clk);
        id_rs = irs; id_rt = irt; ex_rs = ers; ex_rt = ert; ex_rd = erd;
        ex_we = ewe; ex_is_load = eld; mem_rd = mrd; mem_we = mwe;
        wb_rd = wrd; wb_we = wwe;
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        apply(5'd4, 5'd0, 5'd0, 5'd0, 5'd4, 1, 1, 5'd0, 0, 5'd0, 0);
        chk("R10 stall in reset", {1'b0, stall}, 2'b00);
        chk("R10 bubble in reset", {1'b0, bubble}, 2'b00);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_fwd_a;
        apply(5'd0, 5'd0, 5'd3, 5'd9, 5'd0, 0, 0, 5'd3, 1, 5'd7, 1);
        chk("R1 mem to A", fwd_a_sel, 2'b10);
        chk("R4 B untouched", fwd_b_sel, 2'b00);
        apply(5'd0, 5'd0, 5'd7, 5'd9, 5'd0, 0, 0, 5'd3, 1, 5'd7, 1);
        chk("R2 wb to A", fwd_a_sel, 2'b01);
        apply(5'd0, 5'd0, 5'd6, 5'd6, 5'd0, 0, 0, 5'd6, 1, 5'd6, 1);
        chk("R3 priority A", fwd_a_sel, 2'b10);
        chk("R3 priority B", fwd_b_sel, 2'b10);
    endtask

    task automatic t_fwd_b;
        apply(5'd0, 5'd0, 5'd1, 5'd12, 5'd0, 0, 0, 5'd1, 1, 5'd12, 1);
        chk("R4 A from mem", fwd_a_sel, 2'b10);
        chk("R4 B from wb", fwd_b_sel, 2'b01);
    endtask

    task automatic t_zero_we;
        apply(5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 0, 0, 5'd0, 1, 5'd0, 1);
        chk("R5 reg0 A", fwd_a_sel, 2'b00);
        chk("R5 reg0 B", fwd_b_sel, 2'b00);
        apply(5'd0, 5'd0, 5'd5, 5'd5, 5'd0, 0, 0, 5'd5, 0, 5'd5, 0);
        chk("R5 we low A", fwd_a_sel, 2'b00);
        apply(5'd0, 5'd0, 5'd0, 5'd0, 5'd5, 0, 1, 5'd0, 0, 5'd0, 0);
        chk("R5 load we low no stall", {1'b0, stall}, 2'b00);
        apply(5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1, 1, 5'd0, 0, 5'd0, 0);
        chk("R5 load to reg0 no stall", {1'b0, stall}, 2'b00);
    endtask

    task automatic t_load_use;
        apply(5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 0, 0, 5'd0, 0, 5'd0, 0);
        apply(5'd2, 5'd8, 5'd0, 5'd0, 5'd8, 1, 1, 5'd0, 0, 5'd0, 0);
        chk("R6 stall on rt match", {1'b0, stall}, 2'b01);
        chk("R6 bubble on rt match", {1'b0, bubble}, 2'b01);
        // R8: same hazard held one more cycle -> suppressed
        @(negedge clk); #1;
        chk("R8 second cycle no stall", {1'b0, stall}, 2'b00);
        chk("R8 second cycle no bubble", {1'b0, bubble}, 2'b00);
        @(negedge clk); #1;
        chk("R8 back in flow", {1'b0, stall}, 2'b01);
        @(negedge clk); #1;
        // load moved to write-back: forwarded, no stall
        apply(5'd0, 5'd0, 5'd8, 5'd0, 5'd0, 0, 0, 5'd0, 0, 5'd8, 1);
        chk("R6 load data from wb", fwd_a_sel, 2'b01);
        chk("R6 no stall after", {1'b0, stall}, 2'b00);
        apply(5'd8, 5'd0, 5'd0, 5'd0, 5'd8, 1, 1, 5'd0, 0, 5'd0, 0);
        chk("R6 stall on rs match", {1'b0, stall}, 2'b01);
        @(negedge clk); #1;
    endtask

    task automatic t_no_stall;
        apply(5'd2, 5'd8, 5'd0, 5'd0, 5'd8, 1, 0, 5'd0, 0, 5'd0, 0);
        chk("R7 non-load match", {1'b0, stall}, 2'b00);
        apply(5'd2, 5'd3, 5'd0, 5'd0, 5'd8, 1, 1, 5'd0, 0, 5'd0, 0);
        chk("R7 load no match", {1'b0, stall}, 2'b00);
        apply(5'd11, 5'd0, 5'd1, 5'd2, 5'd0, 0, 0, 5'd0, 0, 5'd11, 1);
        chk("R9 wb vs decode stall", {1'b0, stall}, 2'b00);
        chk("R9 wb vs decode sel A", fwd_a_sel, 2'b00);
        chk("R9 wb vs decode sel B", fwd_b_sel, 2'b00);
    endtask

    initial begin
        t_reset();
        t_fwd_a();
        t_fwd_b();
        t_zero_we();
        t_load_use();
        t_no_stall();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule